// File: doc/BRIEF.md
# Peak Level to Decibel Converter

This block turns an unsigned linear peak amplitude into a logarithmic attenuation below full scale. It produces two results from one conversion. The first is a binary attenuation code in quarter-dB steps, which a bar-graph driver can read. The second is the same figure as four decimal digits (hundreds, tens and units of dB, then tenths) for a numeric readout.

A conversion starts with a single-cycle start pulse. The level word is captured on the edge that sees start, and the block works through it sequentially. The log2 of the word comes from its leading-one position plus a fractional refinement that a 16-entry table supplies, indexed by the four bits below the leading one. The result is scaled to decibels by a fixed-point constant multiply. A serial shift-and-add-3 stage then produces the decimal digits.

The outputs stay at their last values until the next conversion completes, and a one-cycle done pulse marks each new result.

Top module: `lvl_log_conv`

## Requirements
- R1: When `start` is high on a rising edge while `busy` is low, `level` is captured on that edge, and `busy` is high in the following cycle and stays high until the conversion ends.
- R2: `done` is high for exactly one cycle. It rises 15 rising edges after the edge that captured `start`, and `busy` is low in that cycle.
- R3: For a nonzero level, take p as the index of the highest set bit and f = floor((level − 2^p)·16 / 2^p), which lies in 0..15. Then frac = round(16·log2(1 + f/16)), and the attenuation in 1/16-octave units is A = (23 − p)·16 − frac.
- R4: For a nonzero level, `atten_qdb` = floor((A·1541 + 512) / 1024), in quarter-dB units of attenuation below full scale.
- R5: A level of zero gives the maximum code `atten_qdb` = 1023 (all ones) and the decimal reading 255.7.
- R6: `dec_bcd` holds T = floor(5·`atten_qdb`/2), the attenuation in tenths of a dB, as four BCD digits: [15:12] hundreds, [11:8] tens, [7:4] units, [3:0] tenths. Each digit is 0..9.
- R7: A `start` pulse while `busy` is high is ignored. The running conversion finishes with its own captured level and its usual latency.
- R8: After synchronous reset, `atten_qdb` and `dec_bcd` are zero and `busy` and `done` are low. Between done pulses, both result outputs hold their values whatever `level` does.
- R9: The largest input, 0x7FFFFF, reads 0.5 dB (`atten_qdb` = 2). The smallest nonzero input, 1, reads 138.5 dB (`atten_qdb` = 554).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion of `level` |
| level | input | 23 | Unsigned linear peak amplitude |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when results update |
| atten_qdb | output | 10 | Attenuation below full scale, quarter-dB steps |
| dec_bcd | output | 16 | Attenuation in BCD: hundreds, tens, units, tenths |

## Verification
The assertions assume only three things about the inputs: reset is synchronous, `start` may arrive in any cycle including while busy, and `level` only matters on the capturing edge. Under those assumptions they check that the captured word cannot move while busy, that done is a lone pulse outside busy, and that every digit leaving the serial stage is decimal. The stimulus changes inputs only on falling edges. It holds `level` steady across the capturing edge, then deliberately changes it and fires extra start pulses mid-conversion and between conversions, so the ignore and hold behaviour is exercised through the ports.

// File: rtl/lvl_log_pkg.sv
package lvl_log_pkg;

    parameter int LVL_W      = 23;
    parameter int FRAC_W     = 4;
    parameter int QDB_W      = 10;
    parameter int SCALE_K    = 1541;
    parameter int SCALE_SH   = 10;
    parameter int BCD_DIGITS = 4;

    parameter int POS_W  = $clog2(LVL_W);
    parameter int ONE_LG = 1 << FRAC_W;
    parameter int ATT_W  = $clog2(LVL_W * ONE_LG + 1);
    parameter int PROD_W = ATT_W + $clog2(SCALE_K + 1) + 1;
    parameter int TEN_W  = QDB_W + 2;
    parameter int BCD_W  = 4 * BCD_DIGITS;
    parameter int CNT_W  = $clog2(TEN_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOG,
        ST_SCALE,
        ST_BCD
    } conv_state_t;

    typedef struct packed {
        logic             zero;
        logic [ATT_W-1:0] att;
    } log_res_t;

    function automatic logic [FRAC_W-1:0] frac_lut(input logic [3:0] sel);
        logic [FRAC_W-1:0] r;
        case (sel)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd3;
            4'd3:  r = 4'd4;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd6;
            4'd6:  r = 4'd7;
            4'd7:  r = 4'd8;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd10;
            4'd10: r = 4'd11;
            4'd11: r = 4'd12;
            4'd12: r = 4'd13;
            4'd13: r = 4'd14;
            4'd14: r = 4'd15;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] bcd_fix(input logic [3:0] d);
        return (d >= 4'd5) ? d + 4'd3 : d;
    endfunction

    function automatic logic all_decimal(input logic [BCD_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BCD_DIGITS; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/lvl_log_front.sv
module lvl_log_front
    import lvl_log_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output log_res_t         res
);

    logic [POS_W-1:0]  lead;
    logic [LVL_W-1:0]  norm;
    logic [FRAC_W-1:0] mant;
    logic [FRAC_W-1:0] frac;
    int                att_i;

    always_comb begin
        lead = '0;
        for (int i = 0; i < LVL_W; i++) begin
            if (lvl[i]) lead = POS_W'(i);
        end
    end

    always_comb begin
        norm  = lvl << (POS_W'(LVL_W - 1) - lead);
        mant  = norm[LVL_W-2 -: FRAC_W];
        frac  = frac_lut(mant);
        att_i = (LVL_W - int'(lead)) * ONE_LG - int'(frac);
        res.zero = (lvl == '0);
        res.att  = ATT_W'(att_i);
    end

endmodule

// File: rtl/lvl_db_scale.sv
module lvl_db_scale
    import lvl_log_pkg::*;
(
    input  log_res_t          lr,
    output logic [QDB_W-1:0]  qdb,
    output logic [TEN_W-1:0]  tenths
);

    logic [PROD_W-1:0] prod;
    logic [TEN_W:0]    five;

    always_comb begin
        prod = PROD_W'(lr.att) * PROD_W'(SCALE_K) + PROD_W'(1 << (SCALE_SH - 1));
        if (lr.zero) qdb = '1;
        else         qdb = prod[SCALE_SH +: QDB_W];
        five   = {1'b0, qdb, 2'b00} + (TEN_W+1)'(qdb);
        tenths = five[TEN_W:1];
    end

endmodule

// File: rtl/lvl_bcd_serial.sv
module lvl_bcd_serial
    import lvl_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TEN_W-1:0] bin,
    output logic [BCD_W-1:0] digits,
    output logic             fin
);

    logic [TEN_W-1:0] sh;
    logic [BCD_W-1:0] acc;
    logic [BCD_W-1:0] adj;
    logic [CNT_W-1:0] cnt;
    logic             run;

    for (genvar g = 0; g < BCD_DIGITS; g++) begin : g_digit
        assign adj[g*4 +: 4] = bcd_fix(acc[g*4 +: 4]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            acc <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                sh  <= bin;
                acc <= '0;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                {acc, sh} <= {adj[BCD_W-2:0], sh, 1'b0};
                cnt       <= cnt + 1'b1;
                if (cnt == CNT_W'(TEN_W - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign digits = acc;

    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
        fin |-> all_decimal(acc)); // R6

    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R2

endmodule

// File: rtl/lvl_log_conv.sv
module lvl_log_conv
    import lvl_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LVL_W-1:0] level,
    output logic             busy,
    output logic             done,
    output logic [QDB_W-1:0] atten_qdb,
    output logic [BCD_W-1:0] dec_bcd
);

    conv_state_t      state;
    logic [LVL_W-1:0] lvl_q;
    log_res_t         lr_c;
    log_res_t         lr_q;
    logic [QDB_W-1:0] q_c;
    logic [QDB_W-1:0] q_q;
    logic [TEN_W-1:0] t_c;
    logic [BCD_W-1:0] digits;
    logic             fin;
    logic             load;

    lvl_log_front u_front (
        .lvl (lvl_q),
        .res (lr_c)
    );

    lvl_db_scale u_scale (
        .lr     (lr_q),
        .qdb    (q_c),
        .tenths (t_c)
    );

    assign load = (state == ST_SCALE);

    lvl_bcd_serial u_bcd (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .bin    (t_c),
        .digits (digits),
        .fin    (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lvl_q     <= '0;
            lr_q      <= '0;
            q_q       <= '0;
            done      <= 1'b0;
            atten_qdb <= '0;
            dec_bcd   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lvl_q <= level;
                        state <= ST_LOG;
                    end
                end
                ST_LOG: begin
                    lr_q  <= lr_c;
                    state <= ST_SCALE;
                end
                ST_SCALE: begin
                    q_q   <= q_c;
                    state <= ST_BCD;
                end
                ST_BCD: begin
                    if (fin) begin
                        atten_qdb <= q_q;
                        dec_bcd   <= digits;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2

    AST_ATT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCALE && !lr_q.zero) |->
            (lr_q.att >= ATT_W'(1) && lr_q.att <= ATT_W'(LVL_W * ONE_LG))); // R3

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCALE && lr_q.zero) |=> (q_q == '1)); // R5

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(lvl_q)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(atten_qdb) && $stable(dec_bcd))); // R8

endmodule

// File: tb/lvl_log_conv_test.sv
module lvl_log_conv_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [22:0] level;
    logic        busy;
    logic        done;
    logic [9:0]  atten_qdb;
    logic [15:0] dec_bcd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lvl_log_conv uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .level     (level),
        .busy      (busy),
        .done      (done),
        .atten_qdb (atten_qdb),
        .dec_bcd   (dec_bcd)
    );

    localparam int NVEC = 12;
    localparam logic [22:0] VEC [NVEC] = '{
        23'h000001, 23'h000002, 23'h000003, 23'h00000F,
        23'h000010, 23'h0001FF, 23'h000F00, 23'h080000,
        23'h123456, 23'h400000, 23'h555555, 23'h7FFFFF
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_q(input logic [22:0] x);
        int p, f, frac, a;
        if (x == 0) return 1023;
        p = 0;
        for (int i = 0; i < 23; i++) if (x[i]) p = i;
        f    = int'(((longint'(x) - (longint'(1) << p)) * 16) >> p);
        frac = $rtoi(16.0 * $ln(1.0 + f / 16.0) / $ln(2.0) + 0.5);
        a    = (23 - p) * 16 - frac;
        return (a * 1541 + 512) / 1024;
    endfunction

    function automatic int model_bcd(input int q);
        int t;
        t = (q * 5) / 2;
        return ((t / 1000) % 10) * 4096 + ((t / 100) % 10) * 256
             + ((t / 10) % 10) * 16 + (t % 10);
    endfunction

    task automatic begin_conv(input logic [22:0] x);
        @(negedge clk);
        level = x;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic convert_check(input logic [22:0] x);
        int lat, q;
        begin_conv(x);
        chk("R1 busy after start", int'(busy), 1);
        wait_done(lat);
        chk("R2 latency", lat, 15);
        chk("R2 busy low with done", int'(busy), 0);
        q = model_q(x);
        chk("R4 atten_qdb", int'(atten_qdb), q);
        chk("R6 dec_bcd", int'(dec_bcd), model_bcd(q));
        @(negedge clk);
        chk("R2 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [9:0]  held_q;
        logic [15:0] held_d;
        rst   = 1'b1;
        start = 1'b0;
        level = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset atten", int'(atten_qdb), 0);
        chk("R8 reset dec", int'(dec_bcd), 0);

        // R3 R4 R6: vector walk
        for (int v = 0; v < NVEC; v++) convert_check(VEC[v]);

        // R9: end points checked against literal values
        convert_check(23'h7FFFFF);
        chk("R9 full scale code", int'(atten_qdb), 2);
        chk("R9 full scale dec", int'(dec_bcd), 16'h0005);
        convert_check(23'h000001);
        chk("R9 smallest code", int'(atten_qdb), 554);
        chk("R9 smallest dec", int'(dec_bcd), 16'h1385);

        // R5: zero input
        convert_check(23'h000000);
        chk("R5 zero code", int'(atten_qdb), 1023);
        chk("R5 zero dec", int'(dec_bcd), 16'h2557);

        // R7: start while busy is ignored
        begin_conv(23'h001000);
        repeat (3) @(negedge clk);
        level = 23'h7FFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk("R7 latency unchanged", lat, 11);
        chk("R7 first level kept", int'(atten_qdb), model_q(23'h001000));
        chk("R7 first level dec", int'(dec_bcd), model_bcd(model_q(23'h001000)));
        repeat (20) begin
            @(negedge clk);
            chk("R7 no second done", int'(done), 0);
        end

        // R8: results hold while level changes and no start
        held_q = atten_qdb;
        held_d = dec_bcd;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            level = 23'h000100 << k;
        end
        chk("R8 atten held", int'(atten_qdb), int'(held_q));
        chk("R8 dec held", int'(dec_bcd), int'(held_d));
        chk("R8 busy idle", int'(busy), 0);

        // R1: back-to-back conversions
        convert_check(23'h000777);
        convert_check(23'h3FFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule